// File: doc/BRIEF.md
# Character-Cell Text Display Controller

This block produces the text layer of a retro computer display on a 640x480, 60 Hz raster driven by a pixel clock of roughly 25.175 MHz. It scans the screen with its own pixel and line counters and generates negative-going horizontal and vertical sync. For every character cell it reads a character code and three attribute bits from an external dual-ported screen memory, then looks up the glyph row for the current scan line. Codes below 128 use a fixed computed pattern. Codes of 128 and above read an internal writable glyph RAM, which the host fills through a write port.

There are 24 text rows in both column modes, and each cell is 16 scan lines tall. In 80-column mode a cell is 8 pixels wide. In 40-column mode each glyph pixel is drawn twice, so a cell is 16 pixels wide. Hardware scrolling rotates the first displayed row: screen row r shows memory row (r + start) mod ROWS, so the screen memory is never copied. The mode and the start row are taken once per frame, at the frame boundary.

The output is a 2-bit intensity: 0 for background, 1 for a dim lit pixel, and 3 for a full lit pixel. Lines below the 384 text lines, and all blanking intervals, show background. The defaults give the 640x480 timing. The bench uses a smaller geometry so that it can run several frames.

Top module: `char_text_display`

## Requirements
- R1: The frame is H_TOT = COLS*8 + H_FP + H_SY + H_BP pixels by V_TOT = V_VIS + V_FP + V_SY + V_BP lines. In 80-column mode, the cell for text row t and column c is read at screen address drow*COLS + c. The glyph row for a code below 128 is code XOR (line << 4), where line (0 to 15) is the scan line within the cell. Bit 7 of the glyph row is the leftmost pixel.
- R2: hsync_n is low exactly for pixel columns COLS*8+H_FP to COLS*8+H_FP+H_SY-1, and high elsewhere.
- R3: vsync_n is low exactly for lines V_VIS+V_FP to V_VIS+V_FP+V_SY-1, and high elsewhere.
- R4: level is 0 for pixels at or beyond column COLS*8, and for lines at or beyond ROWS*16.
- R5: With the latched wide mode set (wide_mode = 1), there are COLS/2 cells per row. Each cell is 16 pixels wide, and each glyph bit covers two pixels. The cell address is drow*(COLS/2) + c.
- R6: The displayed memory row is drow = (t + start) mod ROWS, for start values 0 to ROWS-1.
- R7: Screen data bit 8 (inverse) swaps lit and unlit pixels in the cell.
- R8: Screen data bit 9 (dim) shows lit pixels at level 1 instead of level 3. Unlit pixels are level 0.
- R9: Screen data bit 10 (underline) forces the foreground bit on for scan line 15 of the cell. Inverse is applied after this.
- R10: A code of 128 or above takes its glyph row from the glyph RAM, at address {code[6:0], line}. The RAM is written through gen_we, gen_addr and gen_wdata.
- R11: wide_mode and scroll_row are sampled only on the last pixel of a frame. A change in mid-frame takes effect from the next frame.
- R12: A pixel's effect appears at the outputs two clocks after its counter position. While rst_n is low, level is 0 and both syncs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects 40-column cells; sampled at frame end |
| scroll_row | input | $clog2(ROWS) | First displayed memory row; sampled at frame end |
| scr_addr | output | $clog2(ROWS*COLS) | Screen memory read address (one-cycle read latency) |
| scr_data | input | 11 | {underline, dim, inverse, code[7:0]} |
| gen_we | input | 1 | Glyph RAM write enable |
| gen_addr | input | 11 | Glyph RAM address {code[6:0], line[3:0]} |
| gen_wdata | input | 8 | Glyph RAM row data |
| level | output | 2 | Pixel intensity: 0 off, 1 dim, 3 full |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
The screen is filled with codes from both glyph sources. The attribute bits are spread so that inverse, dim and underline occur alone and in combination. This separates errors in the glyph source, the shading order and the underline line. The bench runs frames in 80- and 40-column modes with several start rows, which tells apart address, stride and wrap errors. Mode and start changes are applied in mid-frame, which exposes any sampling that happens earlier than the frame boundary. Every output is compared on every clock against a behavioural model with a two-clock delay. This also catches a pipeline that is one stage off.

// File: rtl/char_text_display.sv
module char_text_display #(
  parameter int COLS = 80,
  parameter int ROWS = 24,
  parameter int V_VIS = 480,
  parameter int H_FP = 16,
  parameter int H_SY = 96,
  parameter int H_BP = 48,
  parameter int V_FP = 10,
  parameter int V_SY = 2,
  parameter int V_BP = 33,
  localparam int H_VIS = COLS * 8,
  localparam int H_TOT = H_VIS + H_FP + H_SY + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SY + V_BP,
  localparam int TXT = ROWS * 16,
  localparam int HW = $clog2(H_TOT),
  localparam int VW = $clog2(V_TOT),
  localparam int SW = $clog2(ROWS),
  localparam int AW = $clog2(ROWS * COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic [SW-1:0] scroll_row,
  output logic [AW-1:0] scr_addr,
  input  logic [10:0]   scr_data,
  input  logic          gen_we,
  input  logic [10:0]   gen_addr,
  input  logic [7:0]    gen_wdata,
  output logic [1:0]    level,
  output logic          hsync_n,
  output logic          vsync_n
);
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic          wide_q;
  logic [SW-1:0] start_q;
  logic          line_end, frame_end, in_text, hs_now, vs_now;
  logic          act1, hs1, vs1;
  logic [3:0]    line1;
  logic [2:0]    bit1;
  logic [7:0]    gen_mem [0:2047];
  logic [7:0]    rom_row, glyph;
  logic          dot, lit;

  assign line_end  = hc == HW'(H_TOT - 1);
  assign frame_end = line_end && vc == VW'(V_TOT - 1);
  assign in_text   = hc < HW'(H_VIS) && vc < VW'(TXT);
  assign hs_now    = !(hc >= HW'(H_VIS + H_FP) && hc < HW'(H_VIS + H_FP + H_SY));
  assign vs_now    = !(vc >= VW'(V_VIS + V_FP) && vc < VW'(V_VIS + V_FP + V_SY));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
      wide_q <= 1'b0;
      start_q <= '0;
    end else begin
      hc <= line_end ? '0 : hc + 1'b1;
      if (line_end) vc <= frame_end ? '0 : vc + 1'b1;
      if (frame_end) begin
        wide_q <= wide_mode;
        start_q <= scroll_row;
      end
    end
  end

  always_comb begin
    int trow, rs, col;
    trow = int'(vc[VW-1:4]);
    rs = trow + int'(start_q);
    if (rs >= ROWS) rs = rs - ROWS;
    col = wide_q ? int'(hc[HW-1:4]) : int'(hc[HW-1:3]);
    scr_addr = in_text ? AW'(rs * (wide_q ? COLS / 2 : COLS) + col) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act1 <= 1'b0;
      hs1 <= 1'b1;
      vs1 <= 1'b1;
      line1 <= '0;
      bit1 <= '0;
      level <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      act1 <= in_text;
      hs1 <= hs_now;
      vs1 <= vs_now;
      line1 <= vc[3:0];
      bit1 <= wide_q ? hc[3:1] : hc[2:0];
      level <= (act1 && lit) ? (scr_data[9] ? 2'd1 : 2'd3) : 2'd0;
      hsync_n <= hs1;
      vsync_n <= vs1;
    end
  end

  always_ff @(posedge clk)
    if (gen_we) gen_mem[gen_addr] <= gen_wdata;

  assign rom_row = scr_data[7:0] ^ {line1, 4'b0000};
  assign glyph   = scr_data[7] ? gen_mem[{scr_data[6:0], line1}] : rom_row;
  assign dot     = glyph[3'd7 - bit1] | (scr_data[10] & (line1 == 4'hF));
  assign lit     = dot ^ scr_data[8];

  assert_line_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> hc == '0);
  assert_hsync_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> level == 2'd0);
  assert_vsync_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> level == 2'd0);
  assert_vsync_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_n) |-> hsync_n);
  assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_text && int'(start_q) < ROWS) |-> int'(scr_addr) < ROWS * COLS);
  assert_frame_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(start_q) && $stable(wide_q));
endmodule

// File: tb/test_char_text_display.sv
module test_char_text_display;
  localparam int COLS = 16, ROWS = 3, V_VIS = 60;
  localparam int H_FP = 8, H_SY = 16, H_BP = 8, V_FP = 2, V_SY = 2, V_BP = 2;
  localparam int H_TOT = COLS * 8 + H_FP + H_SY + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SY + V_BP;
  localparam int FR = H_TOT * V_TOT;

  logic clk = 0, rst_n = 0, wide = 0, gen_we = 0;
  logic [1:0] start = 0;
  logic [5:0] scr_addr;
  logic [10:0] scr_q = 0;
  logic [10:0] gen_addr = 0;
  logic [7:0] gen_wdata = 0;
  logic [1:0] level;
  logic hsync_n, vsync_n;
  logic [10:0] smem [0:63];
  logic [7:0] gram [0:2047];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  char_text_display #(.COLS(COLS), .ROWS(ROWS), .V_VIS(V_VIS), .H_FP(H_FP), .H_SY(H_SY),
    .H_BP(H_BP), .V_FP(V_FP), .V_SY(V_SY), .V_BP(V_BP)) i_char_text_display (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide), .scroll_row(start), .scr_addr(scr_addr),
    .scr_data(scr_q), .gen_we(gen_we), .gen_addr(gen_addr), .gen_wdata(gen_wdata),
    .level(level), .hsync_n(hsync_n), .vsync_n(vsync_n));

  always @(posedge clk) scr_q <= smem[scr_addr];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  int hm, vm, wm, sm;
  int e1_l, e2_l, e1_h, e2_h, e1_v, e2_v;
  string e1_t, e2_t;

  task automatic model(output int l, output int h, output int v, output string t);
    int line, drow, col, bt, addr, row, px;
    logic [10:0] w;
    h = (hm >= COLS * 8 + H_FP && hm < COLS * 8 + H_FP + H_SY) ? 0 : 1;
    v = (vm >= V_VIS + V_FP && vm < V_VIS + V_FP + V_SY) ? 0 : 1;
    l = 0;
    t = "R4";
    if (hm < COLS * 8 && vm < ROWS * 16) begin
      line = vm % 16;
      drow = (vm / 16 + sm) % ROWS;
      if (wm != 0) begin col = hm / 16; bt = (hm / 2) % 8; addr = drow * (COLS / 2) + col; end
      else begin col = hm / 8; bt = hm % 8; addr = drow * COLS + col; end
      w = smem[addr];
      row = w[7] ? int'(gram[{w[6:0], 4'(line)}]) : int'(w[7:0] ^ 8'(line << 4));
      px = ((row >> (7 - bt)) & 1) | ((w[10] && line == 15) ? 1 : 0);
      if (w[8]) px = px ^ 1;
      l = px != 0 ? (w[9] ? 1 : 3) : 0;
      if (int'(wide) != wm || int'(start) != sm) t = "R11";
      else if (w[7]) t = "R10";
      else if (w[10] && line == 15) t = "R9";
      else if (w[8]) t = "R7";
      else if (w[9]) t = "R8";
      else if (wm != 0) t = "R5";
      else if (sm != 0) t = "R6";
      else t = "R1";
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hm = 0; vm = 0; wm = 0; sm = 0;
      e1_l = 0; e2_l = 0; e1_h = 1; e2_h = 1; e1_v = 1; e2_v = 1;
      e1_t = "R12"; e2_t = "R12";
    end else begin
      int l, h, v;
      string t;
      model(l, h, v, t);
      e2_l = e1_l; e2_h = e1_h; e2_v = e1_v; e2_t = e1_t;
      e1_l = l; e1_h = h; e1_v = v; e1_t = t;
      if (hm == H_TOT - 1) begin
        hm = 0;
        if (vm == V_TOT - 1) begin vm = 0; wm = int'(wide); sm = int'(start); end
        else vm++;
      end else hm++;
    end
  end

  always @(negedge clk)
    if (rst_n && !done) begin
      check(e2_t, int'(level), e2_l);
      check("R2", int'(hsync_n), e2_h);
      check("R3", int'(vsync_n), e2_v);
    end

  initial begin
    for (int i = 0; i < 64; i++)
      smem[i] = {1'(i % 4 == 3), 1'(i % 5 == 2), 1'(i % 3 == 1), 8'((i * 37 + 5) & 255)};
    for (int a = 0; a < 2048; a++) gram[a] = 8'((a * 29 + 7) & 255);
    for (int a = 0; a < 2048; a++) begin
      @(negedge clk);
      gen_we = 1; gen_addr = 11'(a); gen_wdata = gram[a];
    end
    @(negedge clk);
    gen_we = 0;
    check("R12", int'(level), 0);
    check("R12", int'(hsync_n), 1);
    check("R12", int'(vsync_n), 1);
    rst_n = 1;
    repeat (FR / 2) @(negedge clk);
    start = 2;
    repeat (FR) @(negedge clk);
    wide = 1; start = 1;
    repeat (FR) @(negedge clk);
    start = 0;
    repeat (FR) @(negedge clk);
    wide = 0; start = 2;
    repeat (FR + FR / 2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule